// File: doc/BRIEF.md
# Window Mapping Request Validator

This block sits between a management processor's request path and the two control registers of a host-to-internal address remap window. A request carries a command (size query or map), a window type, a window id, a flags word, and a host address, offset and size. The block stores the request, runs it through a chain of sanity checks, and then either ends it with an error or produces its result.

A size query that passes returns the size of the memory region. A map request that passes is encoded into two register writes on one write port. The first is the base write, which holds the translated region address together with the upper half of the host address. The second is the mask write, which holds the inverted size mask together with the size expressed in 64 KiB units minus one. The mask write goes out only when the write sink accepts the base write. The base and size of the flash region and of the memory region are static configuration inputs.

Each request ends in exactly one done pulse, which carries an error flag.

Top module: `winmap_validator`

## Requirements
- R1: After reset `reqReady` is 1 and `doneValid` and `wrValid` are 0. A request is taken on a cycle with `reqValid` and `reqReady` both high. `reqReady` then stays low until the done pulse of that request has been given.
- R2: Any request whose flags word is nonzero is rejected, whatever its command.
- R3: A size query (`reqCmd`=0) is accepted only for window type 2 (memory) with window id 0. It then returns `respSize` equal to the memory region size. A query that is rejected returns `respSize`=0.
- R4: In a map request (`reqCmd`=1), type 1 selects the flash region and type 2 selects the memory region. Any other type is rejected. The window id plays no part in a map request.
- R5: A map request is rejected if bits 15:0 of the size or bits 15:0 of the offset are nonzero.
- R6: A map request is rejected if the offset shares any set bit with (size-1).
- R7: A map request is rejected if offset+size carries out of 32 bits, if offset+size is larger than the selected region size, if the size is zero, or if the size is larger than the region size. A window that exactly fills the region is accepted.
- R8: For an accepted map request, the first write goes to address 0x08 two cycles after the request is taken. Its data is ((region base + offset) mod 2^32) OR (host address >> 16).
- R9: The mask write goes to address 0x0C on the cycle right after the base write. Its data is ~(size-1) OR ((size>>16)-1).
- R10: If `wrFail` is high during the base write, no mask write is issued, and the request ends with an error on the next cycle.
- R11: Every request ends in exactly one single-cycle `doneValid` pulse. The pulse comes 2 cycles after the request is taken for a rejected request or a query, 3 cycles after for a failed base write, and 4 cycles after for a completed map. `doneErr` is 1 only when the request was rejected or its base write failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqCmd | input | 1 | 0 = size query, 1 = map |
| reqType | input | 8 | Window type (1 flash, 2 memory) |
| reqId | input | 8 | Window id |
| reqFlags | input | 16 | Flags word, must be zero |
| reqHostAddr | input | 32 | Host-side address of the window |
| reqOffset | input | 32 | Offset into the selected region |
| reqSize | input | 32 | Window size in bytes |
| cfgFlashBase | input | 32 | Flash region base |
| cfgFlashSize | input | 32 | Flash region size |
| cfgMemBase | input | 32 | Memory region base |
| cfgMemSize | input | 32 | Memory region size |
| wrValid | output | 1 | Register write strobe |
| wrAddr | output | 8 | Register write address (0x08 base, 0x0C mask) |
| wrData | output | 32 | Register write data |
| wrFail | input | 1 | Write sink refuses the write in the current cycle |
| doneValid | output | 1 | Single-cycle end-of-request pulse |
| doneErr | output | 1 | Request rejected or base write failed |
| respSize | output | 32 | Memory region size for an accepted query, else 0 |

## Verification
The bench goes after the edges of the check chain. One case is a window that exactly fills the memory region: a design with an off-by-one bound would wrongly reject it. Another is an offset near the top of the 32-bit space: without the carry check, the sum wraps and an out-of-range mapping is programmed. A zero size is also tried: without that check, a mask of all ones would be written. Other cases are an offset that is 64 KiB aligned but not aligned to the size, a size query sent to the wrong window, and a base write that the sink refuses. A design that got the refused write wrong would still issue the mask write or report success. Expected write data, done timing and response size are compared item by item in arrival order, so a swapped write order or an extra pulse also shows up.

// File: rtl/winmap_pkg.sv
package winmap_pkg;

  localparam logic [7:0] TYPE_FLASH = 8'd1;
  localparam logic [7:0] TYPE_MEM   = 8'd2;

  // control to datapath strobes
  typedef struct packed {
    logic capture;
    logic wrBase;
    logic wrMask;
    logic fin;
  } dpCtl_t;

  // datapath verdict back to control
  typedef struct packed {
    logic isMap;
    logic reject;
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_WBASE, ST_WMASK, ST_FIN
  } ctlState_t;

endpackage

// File: rtl/winmap_dp.sv
module winmap_dp
  import winmap_pkg::*;
#(
  parameter int AW   = 32,
  parameter int GRAN = 16,
  parameter int TW   = 8,
  parameter int FW   = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          reqCmd,
  input  logic [TW-1:0] reqType,
  input  logic [TW-1:0] reqId,
  input  logic [FW-1:0] reqFlags,
  input  logic [AW-1:0] reqHostAddr,
  input  logic [AW-1:0] reqOffset,
  input  logic [AW-1:0] reqSize,
  input  logic [AW-1:0] cfgFlashBase,
  input  logic [AW-1:0] cfgFlashSize,
  input  logic [AW-1:0] cfgMemBase,
  input  logic [AW-1:0] cfgMemSize,
  output dpStat_t       stat,
  output logic [AW-1:0] wrData,
  output logic [AW-1:0] respSize
);

  localparam logic [AW-1:0] LOW_MASK = {{(AW-GRAN){1'b0}}, {GRAN{1'b1}}};
  localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};

  logic          qCmd;
  logic [TW-1:0] qType, qId;
  logic [FW-1:0] qFlags;
  logic [AW-1:0] qHost, qOff, qSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCmd   <= 1'b0;
      qType  <= '0;
      qId    <= '0;
      qFlags <= '0;
      qHost  <= '0;
      qOff   <= '0;
      qSize  <= '0;
    end else if (ctl.capture) begin
      qCmd   <= reqCmd;
      qType  <= reqType;
      qId    <= reqId;
      qFlags <= reqFlags;
      qHost  <= reqHostAddr;
      qOff   <= reqOffset;
      qSize  <= reqSize;
    end
  end

  logic          isFlash, isMem, typeOk;
  logic [AW-1:0] regionBase, regionSize, sizeM1, baseVal, maskVal;
  logic [AW:0]   endSum;
  logic          rejMap, rejQuery;

  always_comb begin
    isFlash    = (qType == TW'(TYPE_FLASH));
    isMem      = (qType == TW'(TYPE_MEM));
    typeOk     = isFlash || isMem;
    regionBase = isFlash ? cfgFlashBase : (isMem ? cfgMemBase : '0);
    regionSize = isFlash ? cfgFlashSize : (isMem ? cfgMemSize : '0);
    sizeM1     = qSize - ONE;
    endSum     = {1'b0, qOff} + {1'b0, qSize};

    // ordered chain: flags, granularity, alignment, type, wrap, bounds
    rejMap = (qFlags != '0)
          || ((qSize & LOW_MASK) != '0) || ((qOff & LOW_MASK) != '0)
          || ((qOff & sizeM1) != '0)
          || !typeOk
          || endSum[AW]
          || (endSum > {1'b0, regionSize})
          || (qSize == '0) || (qSize > regionSize);

    rejQuery = (qFlags != '0) || !isMem || (qId != '0);

    stat.isMap  = qCmd;
    stat.reject = qCmd ? rejMap : rejQuery;

    baseVal = (regionBase + qOff) | (qHost >> GRAN);
    maskVal = ~sizeM1 | ((qSize >> GRAN) - ONE);

    if (ctl.wrBase)      wrData = baseVal;
    else if (ctl.wrMask) wrData = maskVal;
    else                 wrData = '0;

    respSize = (ctl.fin && !qCmd && !rejQuery) ? cfgMemSize : '0;
  end

  // a base write only ever carries a request with clean flags
  assert_base_flags_clean_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrBase |-> (qFlags == '0));

  // writes only for 64 KiB granular size and offset
  assert_write_granular_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrBase || ctl.wrMask) |-> (((qSize | qOff) & LOW_MASK) == '0));

  // written window is nonempty, does not wrap and fits its region
  assert_write_fits_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrBase |-> (qSize != '0 && !endSum[AW] && endSum <= {1'b0, regionSize}));

endmodule

// File: rtl/winmap_ctrl.sv
module winmap_ctrl
  import winmap_pkg::*;
#(
  parameter int          RAW       = 8,
  parameter logic [RAW-1:0] BASE_ADDR = 8'h08,
  parameter logic [RAW-1:0] MASK_ADDR = 8'h0C
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  output logic           reqReady,
  input  dpStat_t        stat,
  input  logic           wrFail,
  output dpCtl_t         ctl,
  output logic           wrValid,
  output logic [RAW-1:0] wrAddr,
  output logic           doneValid,
  output logic           doneErr
);

  ctlState_t st;
  logic      errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      errQ <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE:  if (reqValid) st <= ST_EVAL;
        ST_EVAL: begin
          if (stat.reject) begin
            errQ <= 1'b1;
            st   <= ST_FIN;
          end else if (!stat.isMap) begin
            errQ <= 1'b0;
            st   <= ST_FIN;
          end else begin
            st <= ST_WBASE;
          end
        end
        ST_WBASE: begin
          if (wrFail) begin
            errQ <= 1'b1;
            st   <= ST_FIN;
          end else begin
            st <= ST_WMASK;
          end
        end
        ST_WMASK: begin
          errQ <= 1'b0;
          st   <= ST_FIN;
        end
        ST_FIN:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady    = (st == ST_IDLE);
    ctl.capture = (st == ST_IDLE) && reqValid;
    ctl.wrBase  = (st == ST_WBASE);
    ctl.wrMask  = (st == ST_WMASK);
    ctl.fin     = (st == ST_FIN);
    wrValid     = ctl.wrBase || ctl.wrMask;
    wrAddr      = ctl.wrBase ? BASE_ADDR : (ctl.wrMask ? MASK_ADDR : '0);
    doneValid   = ctl.fin;
    doneErr     = ctl.fin && errQ;
  end

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || wrValid) |-> !reqReady);

  assert_mask_follows_base_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAddr == MASK_ADDR) |-> $past(wrValid && wrAddr == BASE_ADDR && !wrFail));

  assert_fail_no_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAddr == BASE_ADDR && wrFail) |=> (doneValid && doneErr && !wrValid));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

// File: rtl/winmap_validator.sv
module winmap_validator
  import winmap_pkg::*;
#(
  parameter int AW   = 32,
  parameter int GRAN = 16,
  parameter int TW   = 8,
  parameter int FW   = 16,
  parameter int RAW  = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  output logic           reqReady,
  input  logic           reqCmd,
  input  logic [TW-1:0]  reqType,
  input  logic [TW-1:0]  reqId,
  input  logic [FW-1:0]  reqFlags,
  input  logic [AW-1:0]  reqHostAddr,
  input  logic [AW-1:0]  reqOffset,
  input  logic [AW-1:0]  reqSize,
  input  logic [AW-1:0]  cfgFlashBase,
  input  logic [AW-1:0]  cfgFlashSize,
  input  logic [AW-1:0]  cfgMemBase,
  input  logic [AW-1:0]  cfgMemSize,
  output logic           wrValid,
  output logic [RAW-1:0] wrAddr,
  output logic [AW-1:0]  wrData,
  input  logic           wrFail,
  output logic           doneValid,
  output logic           doneErr,
  output logic [AW-1:0]  respSize
);

  dpCtl_t  ctl;
  dpStat_t stat;

  winmap_ctrl #(.RAW(RAW)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .stat(stat), .wrFail(wrFail), .ctl(ctl), .wrValid(wrValid),
    .wrAddr(wrAddr), .doneValid(doneValid), .doneErr(doneErr)
  );

  winmap_dp #(.AW(AW), .GRAN(GRAN), .TW(TW), .FW(FW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqCmd(reqCmd), .reqType(reqType),
    .reqId(reqId), .reqFlags(reqFlags), .reqHostAddr(reqHostAddr),
    .reqOffset(reqOffset), .reqSize(reqSize), .cfgFlashBase(cfgFlashBase),
    .cfgFlashSize(cfgFlashSize), .cfgMemBase(cfgMemBase), .cfgMemSize(cfgMemSize),
    .stat(stat), .wrData(wrData), .respSize(respSize)
  );

endmodule

// File: tb/tb_winmap_validator.sv
module tb_winmap_validator;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [31:0] FLASH_BASE = 32'h3000_0000;
  localparam logic [31:0] FLASH_SIZE = 32'h0400_0000;
  localparam logic [31:0] MEM_BASE   = 32'h9800_0000;
  localparam logic [31:0] MEM_SIZE   = 32'h0010_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqCmd = 1'b0, wrFail = 1'b0;
  logic [7:0] reqType = '0, reqId = '0;
  logic [15:0] reqFlags = '0;
  logic [31:0] reqHostAddr = '0, reqOffset = '0, reqSize = '0;
  logic reqReady, wrValid, doneValid, doneErr;
  logic [7:0] wrAddr;
  logic [31:0] wrData, respSize;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // scoreboard: kind 0 = write, 1 = done
  bit          expKind[$];
  logic [7:0]  expAddr[$];
  logic [31:0] expData[$];
  bit          expErr[$];
  string       expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  winmap_validator dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqType(reqType), .reqId(reqId), .reqFlags(reqFlags),
    .reqHostAddr(reqHostAddr), .reqOffset(reqOffset), .reqSize(reqSize),
    .cfgFlashBase(FLASH_BASE), .cfgFlashSize(FLASH_SIZE),
    .cfgMemBase(MEM_BASE), .cfgMemSize(MEM_SIZE),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrFail(wrFail),
    .doneValid(doneValid), .doneErr(doneErr), .respSize(respSize)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as outputs appear
  always @(negedge clk) begin
    if (rstN) begin
      if (wrValid) begin
        if (expKind.size() == 0 || expKind[0] != 1'b0) begin
          check(1'b0, "R8", "unexpected write addr", {24'd0, wrAddr}, 32'hFFFF_FFFF);
        end else begin
          string t;
          logic [7:0] a;
          logic [31:0] d;
          t = expTag.pop_front();
          a = expAddr.pop_front();
          d = expData.pop_front();
          void'(expKind.pop_front());
          void'(expErr.pop_front());
          check(wrAddr == a, t, "write addr", {24'd0, wrAddr}, {24'd0, a});
          check(wrData == d, t, "write data", wrData, d);
        end
      end
      if (doneValid) begin
        if (expKind.size() == 0 || expKind[0] != 1'b1) begin
          check(1'b0, "R11", "unexpected done", {31'd0, doneErr}, 32'hFFFF_FFFF);
        end else begin
          string t;
          logic [31:0] d;
          bit e;
          t = expTag.pop_front();
          d = expData.pop_front();
          e = expErr.pop_front();
          void'(expKind.pop_front());
          void'(expAddr.pop_front());
          check(doneErr == e, t, "done error", {31'd0, doneErr}, {31'd0, e});
          check(respSize == d, t, "response size", respSize, d);
        end
      end
    end
  end

  function automatic bit modelReject(bit cmd, logic [7:0] ty, logic [7:0] id,
                                     logic [15:0] fl, logic [31:0] off, logic [31:0] sz);
    logic [31:0] rsz;
    logic [32:0] e;
    if (fl != 0) return 1'b1;
    if (!cmd) return !(ty == 8'd2 && id == 8'd0);
    if (sz[15:0] != 0 || off[15:0] != 0) return 1'b1;
    if ((off & (sz - 32'd1)) != 0) return 1'b1;
    if (ty == 8'd1) rsz = FLASH_SIZE;
    else if (ty == 8'd2) rsz = MEM_SIZE;
    else return 1'b1;
    e = {1'b0, off} + {1'b0, sz};
    if (e[32] || e > {1'b0, rsz}) return 1'b1;
    if (sz == 0 || sz > rsz) return 1'b1;
    return 1'b0;
  endfunction

  task automatic send(input bit cmd, input logic [7:0] ty, input logic [7:0] id,
                      input logic [15:0] fl, input logic [31:0] host,
                      input logic [31:0] off, input logic [31:0] sz,
                      input bit failBase, input string tag);
    bit rej;
    int lat, expLat;
    logic [31:0] rbase;
    rej = modelReject(cmd, ty, id, fl, off, sz);
    rbase = (ty == 8'd1) ? FLASH_BASE : MEM_BASE;
    if (!rej && cmd) begin
      expKind.push_back(1'b0); expAddr.push_back(8'h08); expErr.push_back(1'b0);
      expData.push_back((rbase + off) | (host >> 16)); expTag.push_back(tag);
      if (!failBase) begin
        expKind.push_back(1'b0); expAddr.push_back(8'h0C); expErr.push_back(1'b0);
        expData.push_back(~(sz - 32'd1) | ((sz >> 16) - 32'd1)); expTag.push_back(tag);
      end
    end
    expKind.push_back(1'b1); expAddr.push_back(8'h00);
    expErr.push_back(rej || (cmd && failBase));
    expData.push_back((!cmd && !rej) ? MEM_SIZE : 32'd0);
    expTag.push_back(tag);
    expLat = rej || !cmd ? 2 : (failBase ? 3 : 4);

    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqType = ty; reqId = id; reqFlags = fl;
    reqHostAddr = host; reqOffset = off; reqSize = sz; wrFail = failBase;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    check(!reqReady, "R1", "ready while busy", {31'd0, reqReady}, 32'd0);
    while (!doneValid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == expLat, "R11", {tag, " done latency"}, lat, expLat);
    @(negedge clk);
    wrFail = 1'b0;
    check(!doneValid, "R11", "done longer than one cycle", {31'd0, doneValid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reset ready", {31'd0, reqReady}, 32'd1);
    check(doneValid == 1'b0, "R1", "reset done", {31'd0, doneValid}, 32'd0);
    check(wrValid == 1'b0, "R1", "reset write", {31'd0, wrValid}, 32'd0);

    // queries
    send(1'b0, 8'd2, 8'd0, 16'd0, 32'd0, 32'd0, 32'd0, 1'b0, "R3");
    send(1'b0, 8'd1, 8'd0, 16'd0, 32'd0, 32'd0, 32'd0, 1'b0, "R3");
    send(1'b0, 8'd2, 8'd1, 16'd0, 32'd0, 32'd0, 32'd0, 1'b0, "R3");
    send(1'b0, 8'd2, 8'd0, 16'h0001, 32'd0, 32'd0, 32'd0, 1'b0, "R2");
    // good maps
    send(1'b1, 8'd1, 8'd7, 16'd0, 32'h0FFF_0000, 32'd0, 32'h0001_0000, 1'b0, "R8");
    send(1'b1, 8'd2, 8'd0, 16'd0, 32'hE000_0000, 32'h0008_0000, 32'h0008_0000, 1'b0, "R9");
    send(1'b1, 8'd2, 8'd0, 16'd0, 32'h1234_5678, 32'd0, 32'h0010_0000, 1'b0, "R7");
    send(1'b1, 8'd1, 8'd0, 16'd0, 32'hABCD_0000, 32'd0, 32'h0400_0000, 1'b0, "R4");
    // rejects
    send(1'b1, 8'd1, 8'd0, 16'h8000, 32'd0, 32'd0, 32'h0001_0000, 1'b0, "R2");
    send(1'b1, 8'd3, 8'd0, 16'd0, 32'd0, 32'd0, 32'h0001_0000, 1'b0, "R4");
    send(1'b1, 8'd1, 8'd0, 16'd0, 32'd0, 32'd0, 32'h0001_8000, 1'b0, "R5");
    send(1'b1, 8'd1, 8'd0, 16'd0, 32'd0, 32'h0001_0001, 32'h0001_0000, 1'b0, "R5");
    send(1'b1, 8'd1, 8'd0, 16'd0, 32'd0, 32'h0001_0000, 32'h0002_0000, 1'b0, "R6");
    send(1'b1, 8'd2, 8'd0, 16'd0, 32'd0, 32'd0, 32'h0020_0000, 1'b0, "R7");
    send(1'b1, 8'd1, 8'd0, 16'd0, 32'd0, 32'hFFFF_0000, 32'h0001_0000, 1'b0, "R7");
    send(1'b1, 8'd2, 8'd0, 16'd0, 32'd0, 32'd0, 32'd0, 1'b0, "R7");
    send(1'b1, 8'd2, 8'd0, 16'd0, 32'd0, 32'h0010_0000, 32'h0001_0000, 1'b0, "R7");
    // refused base write
    send(1'b1, 8'd2, 8'd0, 16'd0, 32'h0005_0000, 32'h0002_0000, 32'h0001_0000, 1'b1, "R10");
    // recovery after failure
    send(1'b1, 8'd1, 8'd0, 16'd0, 32'h0003_0000, 32'h0002_0000, 32'h0002_0000, 1'b0, "R8");

    repeat (3) @(negedge clk);
    check(expKind.size() == 0, "R11", "items left in scoreboard", expKind.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule